// File: doc/BRIEF.md
# Register-Stack Execution Unit

This block is the evaluation-stack datapath of a processor core. It runs one-byte implicit instructions against a small register stack. The stack is built from flip-flops and is addressed by a count of live entries (S). Next to the stack sit a bank of 16 local registers and a bank of 12 constant registers. Each cycle with `op_valid_i` high, the unit accepts one decoded opcode byte. It then does one of the following:

- combines the two top entries with OR, AND, add or subtract;
- duplicates the top entry;
- discards the top entry, or drops the entry beneath it;
- moves a value between the stack and a local or constant register.

Binary results land in the slot just below the top, and the stack then shrinks by one. For the push and pop forms that name a register, the register number is the low nibble of the opcode.

Some instructions cannot be carried out. An instruction that would push past the last slot, or pop more entries than are present, is rejected: the state is left as it was and a sticky error flag is raised. An opcode outside the supported set does nothing, and the unit answers it with a one-cycle "unsupported" pulse.

The constant registers reset to their own index. Surrounding logic can reload them through a dedicated write port.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset S is 0, the top-of-stack output reads 0, both error flags and the unsupported pulse are low, every local register holds 0 and constant register m holds the value m.
- R2: Opcode 0x40 replaces the two top entries with their bitwise OR, and opcode 0x41 replaces them with their bitwise AND. The result becomes the new top and S drops by one.
- R3: Opcode 0x44 replaces the two top entries with (lower + top + carry) modulo 2^32, and opcode 0x45 replaces them with (lower − top − carry) modulo 2^32. Both clear the carry, which is 0 from reset. The result becomes the new top and S drops by one.
- R4: Opcode 0x48 pushes a copy of the top entry, so S rises by one and the top value is unchanged.
- R5: Opcode 0x49 only lowers S by one.
- R6: Opcode 0x4B keeps the top value, removes the entry directly beneath it, and lowers S by one.
- R7: Opcodes 0x60 to 0x6F push local register n, where n is the opcode's low nibble.
- R8: Opcodes 0x70 to 0x7F pop the top entry into local register n, where n is the opcode's low nibble.
- R9: Opcodes 0x10 to 0x1B push constant register m, where m is the low nibble (0 to 11). A write on the constant port with an index of 12 or more changes no constant.
- R10: A push issued while S equals 16 leaves S and the stack unchanged and sets a sticky overflow flag that only reset clears.
- R11: An instruction that needs more entries than S holds leaves S and the stack unchanged and sets a sticky underflow flag that only reset clears.
- R12: Any opcode not listed in R2 to R9 (for example 0x1C, 0x42, 0x4A) leaves S and the stack unchanged and raises `unsup_o` for exactly the one cycle after it is accepted.
- R13: Every effect appears on the outputs one clock edge after the opcode is accepted; while `op_valid_i` is low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode byte is valid this cycle |
| op_code_i | input | 8 | Decoded opcode byte |
| cw_en_i | input | 1 | Constant register write enable |
| cw_idx_i | input | 4 | Constant register write index |
| cw_data_i | input | 32 | Constant register write data |
| tos_o | output | 32 | Current top-of-stack value (0 when empty) |
| sp_o | output | 5 | Number of live stack entries (S) |
| ovf_err_o | output | 1 | Sticky overflow flag |
| unf_err_o | output | 1 | Sticky underflow flag |
| unsup_o | output | 1 | One-cycle pulse after an unsupported opcode |

## Verification
Every state change lands on the rising edge that accepts the opcode. So S, the top value and both sticky flags are due one edge after the stimulus, and the unsupported pulse is high in that following cycle only. The bench drives each opcode on a falling edge, holds it for exactly one rising edge, and samples on the next falling edge, half a cycle after the update. It then waits one more cycle before checking that the pulse has dropped. Sticky-flag and rejection checks are made after a later legal instruction, so a flag that clears itself, or a push that lands despite the rejection, would show up at the ports.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_BIN,
      CLS_DUP,
      CLS_DIS,
      CLS_XDIS,
      CLS_LPUSH,
      CLS_LPOP,
      CLS_KPUSH
   } stk_cls_e;

   typedef enum logic [1:0] {
      ALU_OR,
      ALU_AND,
      ALU_ADD,
      ALU_SUB
   } stk_alu_e;

   typedef struct packed {
      logic     legal;
      stk_cls_e cls;
      stk_alu_e aop;
      logic [3:0] ridx;
      logic [1:0] need;
      logic     push;
   } stk_dec_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
   import stk_pkg::*;
#(
   parameter int LOC_N = 16,
   parameter int CON_N = 12
) (
   input  logic [7:0] op_i,
   output stk_dec_t   dec_o
);
   localparam logic [4:0] LOC_LIM = 5'(LOC_N);
   localparam logic [4:0] CON_LIM = 5'(CON_N);

   if (LOC_N < 1 || LOC_N > 16) begin : g_loc_chk
      $error("stk_decode: LOC_N must be 1..16");
   end
   if (CON_N < 1 || CON_N > 16) begin : g_con_chk
      $error("stk_decode: CON_N must be 1..16");
   end

   logic [4:0] nib;
   assign nib = {1'b0, op_i[3:0]};

   always_comb begin
      dec_o       = '0;
      dec_o.cls   = CLS_NONE;
      dec_o.aop   = ALU_OR;
      dec_o.ridx  = op_i[3:0];
      case (op_i[7:4])
         4'h1: if (nib < CON_LIM) begin
            dec_o.legal = 1'b1;
            dec_o.cls   = CLS_KPUSH;
            dec_o.push  = 1'b1;
         end
         4'h4: case (op_i[3:0])
            4'h0, 4'h1, 4'h4, 4'h5: begin
               dec_o.legal = 1'b1;
               dec_o.cls   = CLS_BIN;
               dec_o.need  = 2'd2;
               dec_o.aop   = (op_i[2:0] == 3'd0) ? ALU_OR  :
                             (op_i[2:0] == 3'd1) ? ALU_AND :
                             (op_i[2:0] == 3'd4) ? ALU_ADD : ALU_SUB;
            end
            4'h8: begin
               dec_o.legal = 1'b1;
               dec_o.cls   = CLS_DUP;
               dec_o.need  = 2'd1;
               dec_o.push  = 1'b1;
            end
            4'h9: begin
               dec_o.legal = 1'b1;
               dec_o.cls   = CLS_DIS;
               dec_o.need  = 2'd1;
            end
            4'hB: begin
               dec_o.legal = 1'b1;
               dec_o.cls   = CLS_XDIS;
               dec_o.need  = 2'd2;
            end
            default: ;
         endcase
         4'h6: if (nib < LOC_LIM) begin
            dec_o.legal = 1'b1;
            dec_o.cls   = CLS_LPUSH;
            dec_o.push  = 1'b1;
         end
         4'h7: if (nib < LOC_LIM) begin
            dec_o.legal = 1'b1;
            dec_o.cls   = CLS_LPOP;
            dec_o.need  = 2'd1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
   import stk_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  stk_alu_e     op_i,
   output logic [W-1:0] y_o
);
   if (W < 2) begin : g_w_chk
      $error("stk_alu: W must be at least 2");
   end

   logic [W-1:0] cin_ext;
   assign cin_ext = {{(W-1){1'b0}}, cin_i};

   always_comb begin
      case (op_i)
         ALU_OR:  y_o = a_i | b_i;
         ALU_AND: y_o = a_i & b_i;
         ALU_ADD: y_o = a_i + b_i + cin_ext;
         default: y_o = a_i - b_i - cin_ext;
      endcase
   end

endmodule

// File: rtl/stk_regbank.sv
module stk_regbank #(
   parameter int W            = 32,
   parameter int N            = 16,
   parameter int AW           = 4,
   parameter bit RST_IS_INDEX = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [W-1:0]  wd_i,
   input  logic [AW-1:0] ra_i,
   output logic [W-1:0]  rd_o
);
   if (N < 1 || N > (1 << AW)) begin : g_n_chk
      $error("stk_regbank: N must fit the address width");
   end

   logic [N*W-1:0] flat;

   for (genvar g = 0; g < N; g++) begin : g_ent
      logic [W-1:0] q;
      if (RST_IS_INDEX) begin : g_rst_idx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       q <= W'(g);
            else if (we_i && wa_i == AW'(g))  q <= wd_i;
         end
      end else begin : g_rst_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       q <= '0;
            else if (we_i && wa_i == AW'(g))  q <= wd_i;
         end
      end
      assign flat[g*W +: W] = q;
   end

   always_comb begin
      rd_o = '0;
      for (int k = 0; k < N; k++) begin
         if (ra_i == AW'(k)) rd_o = flat[k*W +: W];
      end
   end

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
   import stk_pkg::*;
#(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   parameter int LOC_N = 16,
   parameter int CON_N = 12,
   localparam int SPW  = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           op_valid_i,
   input  logic [7:0]     op_code_i,
   input  logic           cw_en_i,
   input  logic [3:0]     cw_idx_i,
   input  logic [W-1:0]   cw_data_i,
   output logic [W-1:0]   tos_o,
   output logic [SPW-1:0] sp_o,
   output logic           ovf_err_o,
   output logic           unf_err_o,
   output logic           unsup_o
);
   localparam int IW = $clog2(DEPTH);
   localparam logic [SPW-1:0] SP_FULL = SPW'(DEPTH);
   localparam logic [SPW-1:0] SP_ONE  = SPW'(1);
   localparam logic [SPW-1:0] SP_TWO  = SPW'(2);

   if (DEPTH < 2) begin : g_depth_chk
      $error("stack_exec_unit: DEPTH must be at least 2");
   end

   // state
   logic [W-1:0]   stk_q [DEPTH];
   logic [SPW-1:0] sp_q;
   logic           carry_q;
   logic           ovf_q, unf_q, unsup_q;

   // decode
   stk_dec_t dec;
   stk_decode #(.LOC_N(LOC_N), .CON_N(CON_N)) u_dec (
      .op_i  (op_code_i),
      .dec_o (dec)
   );

   // operand fetch
   logic [IW-1:0] top_idx, nxt_idx, push_idx;
   logic [W-1:0]  tos_val, nxt_val, alu_y, loc_rd, con_rd;

   assign top_idx  = IW'(sp_q - SP_ONE);
   assign nxt_idx  = IW'(sp_q - SP_TWO);
   assign push_idx = IW'(sp_q);
   assign tos_val  = (sp_q != '0)    ? stk_q[top_idx] : '0;
   assign nxt_val  = (sp_q >= SP_TWO) ? stk_q[nxt_idx] : '0;

   stk_alu #(.W(W)) u_alu (
      .a_i   (nxt_val),
      .b_i   (tos_val),
      .cin_i (carry_q),
      .op_i  (dec.aop),
      .y_o   (alu_y)
   );

   // fault detection
   logic under, over, op_ok;
   assign under = op_valid_i && dec.legal && (sp_q < SPW'(dec.need));
   assign over  = op_valid_i && dec.legal && !under && dec.push && (sp_q == SP_FULL);
   assign op_ok = op_valid_i && dec.legal && !under && !over;

   // next-state selection
   logic           stk_we, loc_we, clr_carry;
   logic [IW-1:0]  stk_wi;
   logic [W-1:0]   stk_wd;
   logic [SPW-1:0] sp_d;

   always_comb begin
      stk_we    = 1'b0;
      stk_wi    = push_idx;
      stk_wd    = '0;
      sp_d      = sp_q;
      loc_we    = 1'b0;
      clr_carry = 1'b0;
      if (op_ok) begin
         case (dec.cls)
            CLS_BIN: begin
               stk_we    = 1'b1;
               stk_wi    = nxt_idx;
               stk_wd    = alu_y;
               sp_d      = sp_q - SP_ONE;
               clr_carry = (dec.aop == ALU_ADD) || (dec.aop == ALU_SUB);
            end
            CLS_XDIS: begin
               stk_we = 1'b1;
               stk_wi = nxt_idx;
               stk_wd = tos_val;
               sp_d   = sp_q - SP_ONE;
            end
            CLS_DIS:  sp_d = sp_q - SP_ONE;
            CLS_LPOP: begin
               loc_we = 1'b1;
               sp_d   = sp_q - SP_ONE;
            end
            CLS_DUP: begin
               stk_we = 1'b1;
               stk_wd = tos_val;
               sp_d   = sp_q + SP_ONE;
            end
            CLS_LPUSH: begin
               stk_we = 1'b1;
               stk_wd = loc_rd;
               sp_d   = sp_q + SP_ONE;
            end
            CLS_KPUSH: begin
               stk_we = 1'b1;
               stk_wd = con_rd;
               sp_d   = sp_q + SP_ONE;
            end
            default: ;
         endcase
      end
   end

   // register banks
   stk_regbank #(.W(W), .N(LOC_N), .AW(4), .RST_IS_INDEX(1'b0)) u_locals (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (loc_we),
      .wa_i  (dec.ridx),
      .wd_i  (tos_val),
      .ra_i  (dec.ridx),
      .rd_o  (loc_rd)
   );

   stk_regbank #(.W(W), .N(CON_N), .AW(4), .RST_IS_INDEX(1'b1)) u_consts (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (cw_en_i),
      .wa_i  (cw_idx_i),
      .wd_i  (cw_data_i),
      .ra_i  (dec.ridx),
      .rd_o  (con_rd)
   );

   // sequential state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
         sp_q    <= '0;
         carry_q <= 1'b0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
         unsup_q <= 1'b0;
      end else begin
         if (stk_we)    stk_q[stk_wi] <= stk_wd;
         if (clr_carry) carry_q <= 1'b0;
         sp_q    <= sp_d;
         if (over)  ovf_q <= 1'b1;
         if (under) unf_q <= 1'b1;
         unsup_q <= op_valid_i && !dec.legal;
      end
   end

   assign tos_o     = tos_val;
   assign sp_o      = sp_q;
   assign ovf_err_o = ovf_q;
   assign unf_err_o = unf_q;
   assign unsup_o   = unsup_q;

   // R10
   sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= SP_FULL);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R11
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_q |=> unf_q);

   // R11
   under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && dec.legal && sp_q == '0 && dec.need != 2'd0) |=> (sp_q == '0) && unf_q);

   // R10
   over_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && dec.push && sp_q == SP_FULL) |=> (sp_q == SP_FULL) && ovf_q);

   // R12
   unsup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && !dec.legal) |=> (sp_q == $past(sp_q)) && unsup_o);

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid_i |=> (sp_q == $past(sp_q)) && !unsup_o);

   // R4
   dup_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i == 8'h48 && sp_q != '0 && sp_q != SP_FULL)
      |=> (sp_q == $past(sp_q) + SP_ONE) && (tos_o == $past(tos_o)));

   // R2 R3
   bin_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && dec.cls == CLS_BIN && sp_q >= SP_TWO) |=> sp_q == $past(sp_q) - SP_ONE);

   // R6
   xdis_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i == 8'h4B && sp_q >= SP_TWO) |=> tos_o == $past(tos_o));

endmodule

// File: tb/tb_stack_exec_unit.sv
`timescale 1ns/1ps
module tb_stack_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  op_code = 8'h00;
   logic        cw_en = 1'b0;
   logic [3:0]  cw_idx = 4'h0;
   logic [31:0] cw_data = '0;
   logic [31:0] tos;
   logic [4:0]  sp;
   logic        ovf, unf, unsup;

   int errs   = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   stack_exec_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid_i (op_valid),
      .op_code_i  (op_code),
      .cw_en_i    (cw_en),
      .cw_idx_i   (cw_idx),
      .cw_data_i  (cw_data),
      .tos_o      (tos),
      .sp_o       (sp),
      .ovf_err_o  (ovf),
      .unf_err_o  (unf),
      .unsup_o    (unsup)
   );

   // {opcode, sp expected, tos expected}; requirement tag in the comment
   localparam logic [47:0] VEC [16] = '{
      {8'h13, 8'd1, 32'd3},          // R9 push const 3
      {8'h15, 8'd2, 32'd5},          // R9 push const 5
      {8'h40, 8'd1, 32'd7},          // R2 OR
      {8'h1A, 8'd2, 32'd10},         // R9 push const 10
      {8'h41, 8'd1, 32'd2},          // R2 AND
      {8'h48, 8'd2, 32'd2},          // R4 duplicate
      {8'h44, 8'd1, 32'd4},          // R3 add
      {8'h1B, 8'd2, 32'd11},         // R9 push const 11
      {8'h45, 8'd1, 32'hFFFF_FFF9},  // R3 subtract wraps
      {8'h77, 8'd0, 32'd0},          // R8 pop to local 7
      {8'h67, 8'd1, 32'hFFFF_FFF9},  // R7 push local 7
      {8'h11, 8'd2, 32'd1},          // R9 push const 1
      {8'h4B, 8'd1, 32'd1},          // R6 keep top, drop lower
      {8'h49, 8'd0, 32'd0},          // R5 discard
      {8'h60, 8'd1, 32'd0},          // R7 push local 0 (reset value)
      {8'h49, 8'd0, 32'd0}           // R5 discard
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] op);
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = op;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic cwrite(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      cw_en   = 1'b1;
      cw_idx  = idx;
      cw_data = d;
      @(negedge clk);
      cw_en   = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 sp", 32'(sp), 32'd0);
      chk("R1 tos", tos, 32'd0);
      chk("R1 flags", {29'd0, ovf, unf, unsup}, 32'd0);

      // R13 opcode held without valid does nothing
      @(negedge clk);
      op_code = 8'h48;
      @(negedge clk);
      chk("R13 idle sp", 32'(sp), 32'd0);
      chk("R13 idle unsup", 32'(unsup), 32'd0);

      for (int i = 0; i < 16; i++) begin
         issue(VEC[i][47:40]);
         chk($sformatf("vec%0d sp", i), 32'(sp), 32'(VEC[i][39:32]));
         chk($sformatf("vec%0d tos", i), tos, VEC[i][31:0]);
         chk($sformatf("vec%0d flags", i), {29'd0, ovf, unf, unsup}, 32'd0);
      end

      // R1 reset clears locals
      do_reset();
      issue(8'h67);
      chk("R1 local cleared", tos, 32'd0);

      // R11 underflow
      do_reset();
      issue(8'h44);
      chk("R11 empty add unf", 32'(unf), 32'd1);
      chk("R11 empty add sp", 32'(sp), 32'd0);
      issue(8'h13);
      chk("R11 sticky unf", 32'(unf), 32'd1);
      chk("R11 push after sp", 32'(sp), 32'd1);
      issue(8'h4B);
      chk("R11 xdis one entry sp", 32'(sp), 32'd1);
      chk("R11 xdis one entry tos", tos, 32'd3);
      issue(8'h70);
      issue(8'h49);
      chk("R11 discard empty sp", 32'(sp), 32'd0);
      chk("R11 ovf untouched", 32'(ovf), 32'd0);

      // R12 unsupported opcodes
      do_reset();
      issue(8'h11);
      issue(8'h42);
      chk("R12 pulse 0x42", 32'(unsup), 32'd1);
      chk("R12 sp kept", 32'(sp), 32'd1);
      chk("R12 tos kept", tos, 32'd1);
      @(negedge clk);
      chk("R12 pulse ends", 32'(unsup), 32'd0);
      issue(8'h1C);
      chk("R12 pulse 0x1C", 32'(unsup), 32'd1);
      issue(8'h4A);
      chk("R12 pulse 0x4A", 32'(unsup), 32'd1);
      chk("R12 sp after 0x4A", 32'(sp), 32'd1);

      // R9 constant port, then R10 overflow
      do_reset();
      cwrite(4'd12, 32'h0000_AAAA);
      cwrite(4'd2, 32'hDEAD_BEEF);
      for (int m = 0; m < 12; m++) begin
         issue(8'h10 | 8'(m));
         chk($sformatf("R9 const %0d", m), tos, (m == 2) ? 32'hDEAD_BEEF : 32'(m));
      end
      for (int k = 0; k < 4; k++) issue(8'h10);
      chk("R10 full sp", 32'(sp), 32'd16);
      chk("R10 no ovf yet", 32'(ovf), 32'd0);
      issue(8'h13);
      chk("R10 ovf set", 32'(ovf), 32'd1);
      chk("R10 sp held", 32'(sp), 32'd16);
      chk("R10 tos held", tos, 32'd0);
      issue(8'h48);
      chk("R10 dup full sp", 32'(sp), 32'd16);
      issue(8'h49);
      chk("R10 sticky ovf", 32'(ovf), 32'd1);
      chk("R10 sp after discard", 32'(sp), 32'd15);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule